// File: doc/BRIEF.md
# Status Register with Write-Enable Latches

This block holds the 8-bit volatile status byte of a serial clock/calendar device with a nonvolatile array. The byte carries six flags: a backup-supply flag, two alarm flags, a register write-enable latch, a write-enable latch and a clock-fail flag. A bus slave front end decodes the serial protocol. It presents status-register byte writes, read start and read end strobes, and a strobe for each accepted write to the clock registers. The block returns the current status byte. It also drives two permission outputs, which the front end uses to decide whether to acknowledge an array write or a control-register write.

The write latches are controlled by a state machine with three states. `LT_LOCKED` has both latches clear. `LT_ARRAY_OPEN` has only the write-enable latch set. `LT_ALL_OPEN` has both latches set. The transitions are:
- *unlock* (byte 0x02, from any state) leads to `LT_ARRAY_OPEN`.
- *escalate* (byte 0x06, only from `LT_ARRAY_OPEN` or `LT_ALL_OPEN`) leads to `LT_ALL_OPEN`.
- *lock* (byte 0x00, from any state) leads to `LT_LOCKED`.
- Every other byte holds the current state.

A second machine tracks status reads. It has two states, `RD_IDLE` and `RD_ACTIVE`. Transition *open* (read start while idle) snapshots the alarm flags into a clear mask. Transition *close* (read end while active) clears only the masked flags.

All state is cleared by a synchronous active-low reset. The only exception is the clock-fail flag: while reset is held, it loads the power-loss indication.

Top module: `rtc_stat_reg`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: backup flag, alarm-1 flag, alarm-0 flag, 0, 0, register write-enable latch, write-enable latch, clock-fail flag. Bits 4 and 3 always read 0.
- R2: While `rst_n` is low at a clock edge, every bit is cleared, except the clock-fail flag, which takes the value of `pwr_lost_i`.
- R3: The backup flag equals the value `on_backup_i` had at the previous clock edge. Status writes do not change it.
- R4: A high `alarm_hit_i[1]` (resp. `[0]`) at a clock edge sets bit 6 (resp. bit 5). The flag stays set until a read clears it.
- R5: At a read end, only the alarm flags that were set when that read started are cleared. A flag set during the read survives. A hit in the same cycle as the read end leaves the flag set.
- R6: A read end with no read in progress changes nothing. A read start while a read is already in progress is ignored, so the first snapshot is kept.
- R7: Writing 0x02 sets the write-enable latch and clears the register write-enable latch, from any state.
- R8: Writing 0x00 clears both latches.
- R9: Writing 0x06 sets both latches if the write-enable latch is already 1. Otherwise it is ignored.
- R10: Writing any byte other than 0x00, 0x02 and 0x06 leaves both latches unchanged.
- R11: `arr_wr_ok_o` equals the write-enable latch. `ctl_wr_ok_o` is high only when both latches are 1.
- R12: The clock-fail flag is read-only. Status writes never change it. A `ctl_wr_done_i` pulse clears it. After reset, nothing sets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_lost_i | input | 1 | Total power loss seen; loaded into the clock-fail flag during reset |
| on_backup_i | input | 1 | Device is running from the backup supply |
| alarm_hit_i | input | 2 | Alarm match pulses, bit 1 for alarm 1 and bit 0 for alarm 0 |
| sr_wr_en_i | input | 1 | Status-register byte write strobe |
| sr_wr_data_i | input | 8 | Byte written to the status register |
| rd_start_i | input | 1 | A status read begins |
| rd_end_i | input | 1 | Last data bit of the status read has been sent |
| ctl_wr_done_i | input | 1 | A write to the clock registers has been accepted |
| rd_data_o | output | 8 | Current status byte |
| arr_wr_ok_o | output | 1 | Array and control writes may be acknowledged |
| ctl_wr_ok_o | output | 1 | Control-register writes may be acknowledged |

## Verification
The bench runs a table of write patterns against the latch machine:
- The escalate byte is written while locked. A design that granted it would open control writes without the unlock step.
- Near-miss bytes (0x03, 0x04, 0x07, 0xFF) are written. A decoder that tested single bits instead of whole bytes would move the latches.
- Unlock is written from `LT_ALL_OPEN`. A design that kept the register latch would leave control writes enabled.

The alarm tests cover these cases:
- A hit during a read. A design that cleared all flags at read end would lose that event.
- A hit on the same cycle as the read end. Giving the clear priority would drop it.
- A stray read end, and a second read start inside a read. Either would wrongly clear, or change, the snapshot.

The clock-fail flag is written with all ones while set and while clear. This catches a design that let status writes reach it.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
    localparam int SR_W   = 8;
    localparam int ALM_N  = 2;

    localparam int POS_BAT  = 7;
    localparam int POS_AL1  = 6;
    localparam int POS_AL0  = 5;
    localparam int POS_RWE  = 2;
    localparam int POS_WE   = 1;
    localparam int POS_FAIL = 0;

    localparam logic [SR_W-1:0] PAT_LOCK     = 8'h00;
    localparam logic [SR_W-1:0] PAT_UNLOCK   = 8'h02;
    localparam logic [SR_W-1:0] PAT_ESCALATE = 8'h06;

    typedef enum logic [1:0] {
        LT_LOCKED     = 2'd0,
        LT_ARRAY_OPEN = 2'd1,
        LT_ALL_OPEN   = 2'd2
    } latch_st_t;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_ACTIVE = 1'b1
    } rd_st_t;
endpackage

// File: rtl/rtc_stat_latch.sv
module rtc_stat_latch
    import rtc_stat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [SR_W-1:0] wr_data_i,
    output logic            we_o,
    output logic            rwe_o
);
    latch_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LT_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (st_q)
                LT_LOCKED: begin
                    if (wr_data_i == PAT_UNLOCK) st_d = LT_ARRAY_OPEN;
                end
                LT_ARRAY_OPEN: begin
                    if (wr_data_i == PAT_LOCK)          st_d = LT_LOCKED;
                    else if (wr_data_i == PAT_ESCALATE) st_d = LT_ALL_OPEN;
                end
                LT_ALL_OPEN: begin
                    if (wr_data_i == PAT_LOCK)        st_d = LT_LOCKED;
                    else if (wr_data_i == PAT_UNLOCK) st_d = LT_ARRAY_OPEN;
                end
                default: st_d = LT_LOCKED;
            endcase
        end
    end

    always_comb begin
        we_o  = 1'b0;
        rwe_o = 1'b0;
        unique case (st_q)
            LT_LOCKED:     begin we_o = 1'b0; rwe_o = 1'b0; end
            LT_ARRAY_OPEN: begin we_o = 1'b1; rwe_o = 1'b0; end
            LT_ALL_OPEN:   begin we_o = 1'b1; rwe_o = 1'b1; end
            default:       begin we_o = 1'b0; rwe_o = 1'b0; end
        endcase
    end

    AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i == PAT_LOCK) |=> (!we_o && !rwe_o)); // R8
    AST_UNLOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i == PAT_UNLOCK) |=> (we_o && !rwe_o)); // R7
    AST_ESCALATE_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rwe_o)) |-> ($past(we_o) && $past(wr_en_i) && $past(wr_data_i) == PAT_ESCALATE)); // R9
    AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || (wr_data_i != PAT_LOCK && wr_data_i != PAT_UNLOCK
                      && wr_data_i != PAT_ESCALATE)) |=> ($stable(we_o) && $stable(rwe_o))); // R10
endmodule

// File: rtl/rtc_stat_alarm.sv
module rtc_stat_alarm
    import rtc_stat_pkg::*;
#(
    parameter int N = ALM_N
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit_i,
    input  logic         rd_start_i,
    input  logic         rd_end_i,
    output logic [N-1:0] flag_o
);
    rd_st_t       rd_q, rd_d;
    logic [N-1:0] mask_q;
    logic [N-1:0] flag_q;
    logic         open_evt;
    logic         close_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= RD_IDLE;
        else        rd_q <= rd_d;
    end

    always_comb begin
        rd_d      = rd_q;
        open_evt  = 1'b0;
        close_evt = 1'b0;
        unique case (rd_q)
            RD_IDLE: begin
                if (rd_start_i) begin
                    rd_d     = RD_ACTIVE;
                    open_evt = 1'b1;
                end
            end
            RD_ACTIVE: begin
                if (rd_end_i) begin
                    rd_d      = RD_IDLE;
                    close_evt = 1'b1;
                end
            end
            default: rd_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (open_evt)  mask_q <= flag_q;
        else if (close_evt) mask_q <= '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= (flag_q[i] & ~(close_evt & mask_q[i])) | hit_i[i];
        end

        AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i[i] |=> flag_q[i]); // R4
        AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !(close_evt && mask_q[i])) |=> flag_q[i]); // R5
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(hit_i[i])); // R4
    end

    AST_STRAY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q == RD_IDLE && !rd_start_i && !(|hit_i)) |=> $stable(flag_q)); // R6

    assign flag_o = flag_q;
endmodule

// File: rtl/rtc_stat_reg.sv
module rtc_stat_reg
    import rtc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_lost_i,
    input  logic             on_backup_i,
    input  logic [ALM_N-1:0] alarm_hit_i,
    input  logic             sr_wr_en_i,
    input  logic [SR_W-1:0]  sr_wr_data_i,
    input  logic             rd_start_i,
    input  logic             rd_end_i,
    input  logic             ctl_wr_done_i,
    output logic [SR_W-1:0]  rd_data_o,
    output logic             arr_wr_ok_o,
    output logic             ctl_wr_ok_o
);
    logic             bat_q;
    logic             fail_q;
    logic             we;
    logic             rwe;
    logic [ALM_N-1:0] alm;

    always_ff @(posedge clk) begin
        if (!rst_n) bat_q <= 1'b0;
        else        bat_q <= on_backup_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)             fail_q <= pwr_lost_i;
        else if (ctl_wr_done_i) fail_q <= 1'b0;
    end

    rtc_stat_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (sr_wr_en_i),
        .wr_data_i (sr_wr_data_i),
        .we_o      (we),
        .rwe_o     (rwe)
    );

    rtc_stat_alarm #(.N(ALM_N)) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (alarm_hit_i),
        .rd_start_i (rd_start_i),
        .rd_end_i   (rd_end_i),
        .flag_o     (alm)
    );

    always_comb begin
        rd_data_o           = '0;
        rd_data_o[POS_BAT]  = bat_q;
        rd_data_o[POS_AL1]  = alm[1];
        rd_data_o[POS_AL0]  = alm[0];
        rd_data_o[POS_RWE]  = rwe;
        rd_data_o[POS_WE]   = we;
        rd_data_o[POS_FAIL] = fail_q;
    end

    assign arr_wr_ok_o = we;
    assign ctl_wr_ok_o = we & rwe;

    AST_FAIL_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[POS_FAIL] |=> !rd_data_o[POS_FAIL]); // R12
    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[POS_FAIL] && !ctl_wr_done_i) |=> rd_data_o[POS_FAIL]); // R12
    AST_CTL_IMPLIES_ARR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_ok_o |-> arr_wr_ok_o); // R11
    AST_GAP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[4:3] == 2'b00); // R1
    AST_BAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        on_backup_i |=> rd_data_o[POS_BAT]); // R3
endmodule

// File: tb/sim_rtc_stat_reg.sv
module sim_rtc_stat_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_lost = 1'b1;
    logic       on_backup = 1'b0;
    logic [1:0] hit = 2'b00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_start = 1'b0;
    logic       rd_end = 1'b0;
    logic       ctl_done = 1'b0;
    logic [7:0] rd_data;
    logic       arr_ok;
    logic       ctl_ok;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    rtc_stat_reg u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_lost_i    (pwr_lost),
        .on_backup_i   (on_backup),
        .alarm_hit_i   (hit),
        .sr_wr_en_i    (wr_en),
        .sr_wr_data_i  (wr_data),
        .rd_start_i    (rd_start),
        .rd_end_i      (rd_end),
        .ctl_wr_done_i (ctl_done),
        .rd_data_o     (rd_data),
        .arr_wr_ok_o   (arr_ok),
        .ctl_wr_ok_o   (ctl_ok)
    );

    // {write byte, expected {register latch, write latch}} starting from locked
    localparam logic [9:0] VEC [0:11] = '{
        {8'h06, 2'b00}, {8'h04, 2'b00}, {8'h02, 2'b01}, {8'hFF, 2'b01},
        {8'h06, 2'b11}, {8'h02, 2'b01}, {8'h06, 2'b11}, {8'h07, 2'b11},
        {8'h00, 2'b00}, {8'h02, 2'b01}, {8'h03, 2'b01}, {8'h00, 2'b00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_hit(input logic [1:0] h);
        @(negedge clk); hit = h;
        @(negedge clk); hit = 2'b00;
    endtask

    task automatic pulse_start();
        @(negedge clk); rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
    endtask

    task automatic pulse_end(input logic [1:0] h);
        @(negedge clk); rd_end = 1'b1; hit = h;
        @(negedge clk); rd_end = 1'b0; hit = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pwr_lost = 1'b0;
        @(negedge clk);
        chk("R2 reset after power loss", rd_data, 8'h01);
        chk("R11 reset grants", {6'b0, ctl_ok, arr_ok}, 8'h00);

        wr(8'hFF);
        chk("R12 write keeps fail, R1 gaps zero", rd_data, 8'h01);
        @(negedge clk); ctl_done = 1'b1;
        @(negedge clk); ctl_done = 1'b0;
        chk("R12 ctl write clears fail", rd_data, 8'h00);
        wr(8'h01);
        chk("R12 status write cannot set fail", rd_data, 8'h00);

        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][9:2]);
            chk("R7 R8 R9 R10 latch table", {5'b0, rd_data[2:1], 1'b0}, {5'b0, VEC[i][1:0], 1'b0});
            chk("R11 grants", {6'b0, ctl_ok, arr_ok}, {6'b0, VEC[i][1] & VEC[i][0], VEC[i][0]});
        end

        @(negedge clk); on_backup = 1'b1;
        @(negedge clk);
        chk("R3 backup flag follows", rd_data, 8'h80);
        wr(8'h00);
        chk("R3 write leaves backup flag", rd_data, 8'h80);
        on_backup = 1'b0;
        @(negedge clk);
        chk("R3 backup flag drops", rd_data, 8'h00);

        pulse_hit(2'b10);
        chk("R4 alarm1 sets", rd_data, 8'h40);
        repeat (3) @(negedge clk);
        chk("R4 alarm1 holds", rd_data, 8'h40);
        pulse_start();
        pulse_hit(2'b01);
        pulse_start();
        chk("R6 second start ignored", rd_data, 8'h60);
        pulse_end(2'b00);
        chk("R5 only snapshot cleared", rd_data, 8'h20);
        pulse_end(2'b00);
        chk("R6 stray end ignored", rd_data, 8'h20);
        pulse_start();
        pulse_end(2'b01);
        chk("R5 hit on end wins", rd_data, 8'h20);
        pulse_start();
        pulse_end(2'b00);
        chk("R5 read clears alarm0", rd_data, 8'h00);

        wr(8'h02);
        pulse_hit(2'b11);
        @(negedge clk); rst_n = 1'b0; pwr_lost = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R2 warm reset clears all", rd_data, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule